// File: doc/BRIEF.md
# USB Host Controller Command and Status Registers

This unit holds the command and status register logic of a high-speed USB host controller. Software reaches it through a small synchronous read/write port with three word addresses: command, status and interrupt enable. The command word starts and stops the controller, launches a controller-wide reset, enables the periodic and asynchronous schedules, picks the frame list length and rings the asynchronous-advance doorbell. The status word reports whether the controller is halted and whether an asynchronous advance has completed.

The unit does not walk schedules itself. It drives three handshakes toward the schedule engine. A stop request is held until the engine reports that its pipeline is idle. A doorbell request is held until the engine reports that its cached schedule state has been evicted. A one-cycle reset pulse starts a reset that lasts until the engine reports that it has finished. An interrupt request is raised only at interrupt-threshold ticks and stays up until its cause goes away.

Top module: `hc_cmd_status_unit`

## Requirements
- R1: After `rst_n` is released, the command word reads 0, the status word reads 1 (halted set, advance flag clear), the enable word reads 0 and `irq` is 0.
- R2: Reads are combinational. Address 0 returns the command word {doorbell[6], async enable[5], periodic enable[4], frame list code[3:2], reset in progress[1], run[0]}. Address 1 returns {advance flag[1], halted[0]}. Address 2 returns the advance interrupt enable in bit 0. Address 3 returns 0.
- R3: `skip_periodic` is the inverse of command bit 4, and `skip_async` is the inverse of command bit 5.
- R4: Command bits 3:2 take a written value only while `fl_prog_cap` is 1. `fl_len` reports 1024, 512 or 256 entries for codes 00, 01 and 10, and 0 for the reserved code 11.
- R5: A command write with bit 0 set clears halted at that edge. After bit 0 is cleared, `stop_req` is 1 until `idle_ack` is sampled high, and halted is set at that edge.
- R6: A command write with bits 6 and 5 both set makes the doorbell bit and `door_req` 1. At the edge where `evict_ack` is sampled with `door_req` high, the advance flag is set and `door_req` drops. The doorbell bit clears one cycle later.
- R7: A doorbell write whose bit 5 is 0 is ignored: the doorbell bit and `door_req` stay 0.
- R8: Writing 1 to status bit 1 clears the advance flag. A set from an eviction in the same cycle wins over the clear.
- R9: `irq` rises at an edge where `irq_tick` is sampled while the advance flag and its enable are both 1 after that edge. It stays up until the flag or the enable goes to 0, and drops at that same edge. With the enable at 0 it never rises.
- R10: A command write with bit 1 set gives a one-cycle `rst_pulse` and returns every operational bit to its R1 value. Command bit 1 reads 1 and all register writes are ignored until `rst_done` is sampled, and the bit clears at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register word address |
| csr_wdata | input | 7 | Write data |
| csr_rdata | output | 7 | Read data for `csr_addr` |
| fl_prog_cap | input | 1 | Frame list length may be programmed |
| irq_tick | input | 1 | Interrupt threshold tick |
| stop_req | output | 1 | Ask the engine to drain and stop |
| idle_ack | input | 1 | Engine pipeline is idle |
| door_req | output | 1 | Ask the engine to evict cached async state |
| evict_ack | input | 1 | Engine has evicted the cached state |
| rst_pulse | output | 1 | One-cycle reset start to the engine |
| rst_done | input | 1 | Engine has finished its reset |
| skip_periodic | output | 1 | Engine skips the periodic schedule |
| skip_async | output | 1 | Engine skips the asynchronous schedule |
| fl_size | output | 2 | Frame list length code |
| fl_len | output | 11 | Frame list length in entries |
| irq | output | 1 | Interrupt request |

## Verification
Each register, flag and engine request changes at the first clock edge that samples its cause. The one exception is the doorbell bit, which clears one edge after the eviction acknowledge. The read port and the skip and length outputs follow the stored bits without delay. The bench applies each stimulus for exactly one edge, starting at a falling edge. It reads both words and the outputs at the next falling edge, so every result is checked one edge after its cause. The delayed doorbell clear is checked on a separate step that has no stimulus.

// File: rtl/hc_csr_pkg.sv
package hc_csr_pkg;
  // command word bit positions (decoded by the engine side as well)
  localparam int CMD_RUN  = 0;
  localparam int CMD_RST  = 1;
  localparam int CMD_FLS  = 2;
  localparam int CMD_PSE  = 4;
  localparam int CMD_ASE  = 5;
  localparam int CMD_DOOR = 6;
  // status word bit positions
  localparam int STS_HALT = 0;
  localparam int STS_AADV = 1;
  // word addresses
  localparam int A_CMD = 0;
  localparam int A_STS = 1;
  localparam int A_IEN = 2;

  function automatic logic [10:0] fl_entries(input logic [1:0] code);
    case (code)
      2'b00:   return 11'd1024;
      2'b01:   return 11'd512;
      2'b10:   return 11'd256;
      default: return 11'd0;
    endcase
  endfunction
endpackage

// File: rtl/hc_reset_seq.sv
module hc_reset_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic done,
  output logic in_rst,
  output logic rst_pulse
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_rst <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      seen_q <= in_rst;
      if (start)     in_rst <= 1'b1;
      else if (done) in_rst <= 1'b0;
    end
  end

  assign rst_pulse = in_rst & ~seen_q;

  // R10: reset ends only after the engine reports completion
  a_r10_ends_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_rst) |-> $past(done));
  // R10: start pulse lasts one cycle
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |=> !rst_pulse);
endmodule

// File: rtl/hc_run_ctrl.sv
module hc_run_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run_wr,
  input  logic run_val,
  input  logic idle_ack,
  output logic run,
  output logic halted,
  output logic stop_req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      halted <= 1'b1;
    end else if (clr) begin
      run    <= 1'b0;
      halted <= 1'b1;
    end else begin
      if (run_wr) run <= run_val;
      if (run_wr && run_val)       halted <= 1'b0;
      else if (stop_req && idle_ack) halted <= 1'b1;
    end
  end

  assign stop_req = ~run & ~halted;

  // R5: halted only sets after the engine drained, or by a reset
  a_r5_halt_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> ($past(idle_ack) || $past(clr)));
  // R5: a running controller is never reported halted
  a_r5_run_not_halted: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> !halted);
endmodule

// File: rtl/hc_door_ctrl.sv
module hc_door_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic ring,
  input  logic evict_ack,
  input  logic sts_w1c,
  input  logic en_wr,
  input  logic en_val,
  input  logic tick,
  output logic iaad,
  output logic door_req,
  output logic aa_sts,
  output logic aa_en,
  output logic irq
);
  logic evict_seen;
  logic evict_evt;
  logic aa_sts_n, aa_en_n, irq_n;

  assign door_req  = iaad & ~evict_seen;
  assign evict_evt = door_req & evict_ack;

  always_comb begin
    aa_sts_n = aa_sts;
    if (evict_evt)    aa_sts_n = 1'b1;
    else if (sts_w1c) aa_sts_n = 1'b0;
    aa_en_n = en_wr ? en_val : aa_en;
    if (clr) begin
      aa_sts_n = 1'b0;
      aa_en_n  = 1'b0;
    end
    irq_n = (aa_sts_n & aa_en_n) ? (irq | tick) : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iaad <= 1'b0; evict_seen <= 1'b0;
      aa_sts <= 1'b0; aa_en <= 1'b0; irq <= 1'b0;
    end else begin
      aa_sts <= aa_sts_n;
      aa_en  <= aa_en_n;
      irq    <= irq_n;
      if (clr) begin
        iaad <= 1'b0; evict_seen <= 1'b0;
      end else begin
        evict_seen <= evict_evt;
        if (evict_seen) iaad <= 1'b0;
        else if (ring)  iaad <= 1'b1;
      end
    end
  end

  // R6: doorbell retires only after the advance flag was set
  a_r6_clear_after_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iaad) |-> ($past(aa_sts) || $past(clr)));
  // R7: doorbell only rises from an accepted ring
  a_r7_rise_from_ring: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iaad) |-> $past(ring));
  // R9: request is only up while its cause is present
  a_r9_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (aa_sts && aa_en));
  // R9: request rises only on a threshold tick
  a_r9_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(tick));
endmodule

// File: rtl/hc_cmd_status_unit.sv
module hc_cmd_status_unit #(
  parameter int AW = 2,
  parameter int DW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csr_we,
  input  logic [AW-1:0] csr_addr,
  input  logic [DW-1:0] csr_wdata,
  output logic [DW-1:0] csr_rdata,
  input  logic          fl_prog_cap,
  input  logic          irq_tick,
  output logic          stop_req,
  input  logic          idle_ack,
  output logic          door_req,
  input  logic          evict_ack,
  output logic          rst_pulse,
  input  logic          rst_done,
  output logic          skip_periodic,
  output logic          skip_async,
  output logic [1:0]    fl_size,
  output logic [10:0]   fl_len,
  output logic          irq
);
  import hc_csr_pkg::*;

  logic in_rst, rst_start, clr;
  logic sel_cmd, sel_sts, sel_ien, wr_cmd;
  logic run, halted, iaad, aa_sts, aa_en;
  logic pse, ase;
  logic [1:0] fls;

  assign sel_cmd   = csr_addr == AW'(A_CMD);
  assign sel_sts   = csr_addr == AW'(A_STS);
  assign sel_ien   = csr_addr == AW'(A_IEN);
  assign wr_cmd    = csr_we & sel_cmd & ~in_rst;
  assign rst_start = wr_cmd & csr_wdata[CMD_RST];
  assign clr       = rst_start | in_rst;

  hc_reset_seq u_rst (
    .clk(clk), .rst_n(rst_n), .start(rst_start), .done(rst_done),
    .in_rst(in_rst), .rst_pulse(rst_pulse)
  );

  hc_run_ctrl u_run (
    .clk(clk), .rst_n(rst_n), .clr(clr), .run_wr(wr_cmd),
    .run_val(csr_wdata[CMD_RUN]), .idle_ack(idle_ack),
    .run(run), .halted(halted), .stop_req(stop_req)
  );

  hc_door_ctrl u_door (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .ring(wr_cmd & csr_wdata[CMD_DOOR] & csr_wdata[CMD_ASE]),
    .evict_ack(evict_ack),
    .sts_w1c(csr_we & sel_sts & csr_wdata[STS_AADV]),
    .en_wr(csr_we & sel_ien & ~in_rst), .en_val(csr_wdata[0]),
    .tick(irq_tick),
    .iaad(iaad), .door_req(door_req), .aa_sts(aa_sts), .aa_en(aa_en), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pse <= 1'b0; ase <= 1'b0; fls <= 2'b00;
    end else if (clr) begin
      pse <= 1'b0; ase <= 1'b0; fls <= 2'b00;
    end else if (wr_cmd) begin
      pse <= csr_wdata[CMD_PSE];
      ase <= csr_wdata[CMD_ASE];
      if (fl_prog_cap) fls <= csr_wdata[CMD_FLS +: 2];
    end
  end

  always_comb begin
    csr_rdata = '0;
    if (sel_cmd) begin
      csr_rdata[CMD_RUN]      = run;
      csr_rdata[CMD_RST]      = in_rst;
      csr_rdata[CMD_FLS +: 2] = fls;
      csr_rdata[CMD_PSE]      = pse;
      csr_rdata[CMD_ASE]      = ase;
      csr_rdata[CMD_DOOR]     = iaad;
    end else if (sel_sts) begin
      csr_rdata[STS_HALT] = halted;
      csr_rdata[STS_AADV] = aa_sts;
    end else if (sel_ien) begin
      csr_rdata[0] = aa_en;
    end
  end

  assign skip_periodic = ~pse;
  assign skip_async    = ~ase;
  assign fl_size       = fls;
  assign fl_len        = fl_entries(fls);

  // R4: the length code moves only with the capability set, or on reset
  a_r4_fls_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fls) |-> ($past(fl_prog_cap) || $past(clr)));
  // R10: during a reset the schedules stay disabled
  a_r10_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    in_rst |-> (skip_periodic && skip_async && !door_req));
endmodule

// File: tb/tb_hc_cmd_status_unit.sv
module tb_hc_cmd_status_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic csr_we = 1'b0;
  logic [1:0] csr_addr = '0;
  logic [6:0] csr_wdata = '0;
  logic [6:0] csr_rdata;
  logic fl_prog_cap = 1'b1, irq_tick = 1'b0, idle_ack = 1'b0;
  logic evict_ack = 1'b0, rst_done = 1'b0;
  logic stop_req, door_req, rst_pulse, skip_periodic, skip_async, irq;
  logic [1:0] fl_size;
  logic [10:0] fl_len;
  int total = 0, bad = 0;
  bit finished = 0;

  hc_cmd_status_unit dut (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .fl_prog_cap(fl_prog_cap),
    .irq_tick(irq_tick), .stop_req(stop_req), .idle_ack(idle_ack),
    .door_req(door_req), .evict_ack(evict_ack), .rst_pulse(rst_pulse),
    .rst_done(rst_done), .skip_periodic(skip_periodic), .skip_async(skip_async),
    .fl_size(fl_size), .fl_len(fl_len), .irq(irq)
  );

  always #5 clk = ~clk;

  // vector: {we, addr[1:0], wdata[6:0], idle, evict, done, tick, cap,
  //          exp_cmd[6:0], exp_sts[1:0], exp_out[3:0] = {irq,door,stop,rstp}}
  localparam int NV = 22;
  localparam logic [27:0] VECS [NV] = '{
    {1'b0, 2'd0, 7'h00, 5'b00001, 7'h00, 2'b01, 4'b0000}, // R1 idle after reset
    {1'b1, 2'd0, 7'h31, 5'b00001, 7'h31, 2'b00, 4'b0000}, // R5 run clears halted
    {1'b1, 2'd2, 7'h01, 5'b00001, 7'h31, 2'b00, 4'b0000}, // R2 enable write
    {1'b1, 2'd0, 7'h71, 5'b00001, 7'h71, 2'b00, 4'b0100}, // R6 ring doorbell
    {1'b0, 2'd0, 7'h00, 5'b00001, 7'h71, 2'b00, 4'b0100}, // R6 waits for eviction
    {1'b0, 2'd0, 7'h00, 5'b01001, 7'h71, 2'b10, 4'b0000}, // R6 flag set, req drops
    {1'b0, 2'd0, 7'h00, 5'b00001, 7'h31, 2'b10, 4'b0000}, // R6 doorbell clears later
    {1'b0, 2'd0, 7'h00, 5'b00011, 7'h31, 2'b10, 4'b1000}, // R9 irq on tick
    {1'b0, 2'd0, 7'h00, 5'b00001, 7'h31, 2'b10, 4'b1000}, // R9 irq held
    {1'b1, 2'd1, 7'h02, 5'b00001, 7'h31, 2'b00, 4'b0000}, // R8 W1C, R9 irq drops
    {1'b0, 2'd0, 7'h00, 5'b00011, 7'h31, 2'b00, 4'b0000}, // R9 tick without cause
    {1'b1, 2'd0, 7'h51, 5'b00001, 7'h11, 2'b00, 4'b0000}, // R7 ring with async off
    {1'b1, 2'd0, 7'h10, 5'b00001, 7'h10, 2'b00, 4'b0010}, // R5 stop requested
    {1'b0, 2'd0, 7'h00, 5'b00001, 7'h10, 2'b00, 4'b0010}, // R5 waits for drain
    {1'b0, 2'd0, 7'h00, 5'b10001, 7'h10, 2'b01, 4'b0000}, // R5 halted after idle
    {1'b1, 2'd0, 7'h08, 5'b00000, 7'h00, 2'b01, 4'b0000}, // R4 code locked, cap 0
    {1'b1, 2'd0, 7'h08, 5'b00001, 7'h08, 2'b01, 4'b0000}, // R4 code taken, cap 1
    {1'b1, 2'd0, 7'h01, 5'b00001, 7'h01, 2'b00, 4'b0000}, // R5 run again
    {1'b1, 2'd0, 7'h02, 5'b00001, 7'h02, 2'b01, 4'b0001}, // R10 reset start pulse
    {1'b1, 2'd0, 7'h00, 5'b00001, 7'h02, 2'b01, 4'b0000}, // R10 zero cannot abort
    {1'b1, 2'd0, 7'h31, 5'b00001, 7'h02, 2'b01, 4'b0000}, // R10 writes ignored
    {1'b0, 2'd0, 7'h00, 5'b00101, 7'h00, 2'b01, 4'b0000}  // R10 ends on done
  };

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // one stimulus for one edge, from falling edge to falling edge
  task automatic step(input logic we, input logic [1:0] a, input logic [6:0] wd,
                      input logic [4:0] ctl);
    csr_we = we; csr_addr = a; csr_wdata = wd;
    {idle_ack, evict_ack, rst_done, irq_tick, fl_prog_cap} = ctl;
    @(posedge clk);
    @(negedge clk);
    csr_we = 1'b0; idle_ack = 1'b0; evict_ack = 1'b0; rst_done = 1'b0; irq_tick = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [6:0] d);
    csr_addr = a;
    #1;
    d = csr_rdata;
  endtask

  initial begin
    logic [6:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [27:0] v;
      v = VECS[i];
      step(v[27], v[26:25], v[24:18], v[17:13]);
      rd(2'd0, d); check($sformatf("vec %0d cmd", i), d, v[12:6]);
      rd(2'd1, d); check($sformatf("vec %0d sts", i), d, v[5:4]);
      check($sformatf("vec %0d outs", i), {irq, door_req, stop_req, rst_pulse}, v[3:0]);
    end

    // R2 enable readback and unused address
    step(1'b1, 2'd2, 7'h01, 5'b00001);
    rd(2'd2, d); check("R2 enable reads 1", d, 1);
    rd(2'd3, d); check("R2 address 3 reads 0", d, 0);

    // R1 asynchronous reset returns every default
    rst_n = 1'b0; #2; rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, d); check("R1 cmd default", d, 0);
    rd(2'd1, d); check("R1 sts default", d, 1);
    rd(2'd2, d); check("R1 enable default", d, 0);
    check("R1 irq default", irq, 0);

    // R3 schedule skip outputs
    step(1'b1, 2'd0, 7'h10, 5'b00001);
    check("R3 periodic on", {skip_periodic, skip_async}, 2'b01);
    step(1'b1, 2'd0, 7'h20, 5'b00001);
    check("R3 async on", {skip_periodic, skip_async}, 2'b10);

    // R4 length decode
    step(1'b1, 2'd0, 7'h00, 5'b00001);
    check("R4 code 00 length", fl_len, 1024);
    step(1'b1, 2'd0, 7'h04, 5'b00001);
    check("R4 code 01 length", fl_len, 512);
    step(1'b1, 2'd0, 7'h08, 5'b00001);
    check("R4 code 10 length", fl_len, 256);
    step(1'b1, 2'd0, 7'h0C, 5'b00001);
    check("R4 reserved length", fl_len, 0);
    step(1'b1, 2'd0, 7'h00, 5'b00000);
    check("R4 locked code kept", fl_size, 3);

    // R9 masked flag, then enable on a tick, then disable
    step(1'b1, 2'd0, 7'h61, 5'b00001);
    step(1'b0, 2'd0, 7'h00, 5'b01001);
    step(1'b0, 2'd0, 7'h00, 5'b00011);
    check("R9 masked no irq", irq, 0);
    rd(2'd1, d); check("R9 flag still set", d, 2);
    step(1'b1, 2'd2, 7'h01, 5'b00011);
    check("R9 irq on enable plus tick", irq, 1);
    step(1'b1, 2'd2, 7'h00, 5'b00001);
    check("R9 irq drops with enable", irq, 0);

    // R8 set wins over a same-cycle clear
    step(1'b1, 2'd1, 7'h02, 5'b00001);
    rd(2'd1, d); check("R8 flag cleared", d, 0);
    step(1'b1, 2'd0, 7'h61, 5'b00001);
    step(1'b1, 2'd1, 7'h02, 5'b01001);
    rd(2'd1, d); check("R8 set beats clear", d, 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    finished = 1;
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got running expected done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule